// File: doc/BRIEF.md
# Effective Address Generation Unit

This block turns the address fields of a memory operand into a 32-bit offset. The offset is then moved into the address space of a segment. It has an internal bank of eight general registers. Any register can supply a base term. Any register except the stack pointer can supply an index term, and the index is multiplied by 1, 2, 4 or 8. An immediate displacement can be added; it is 8, 16 or 32 bits wide, and the shorter widths are sign-extended. Each of the three terms may be left out. The result is the effective address, and a separate output gives that address plus a segment base.

A request is a single-cycle strobe that carries all fields. Most field combinations produce their result one clock after the request. A request that uses a base and an index together is split over two clocks. During the extra clock the block raises `busy` and ignores new strobes. A request that names the stack pointer as an index is refused: the block pulses a fault flag and does not finish the request. The register bank has a write port so that a test can load register values.

Top module: `addr_gen_unit`

## Requirements
- R1: `effAddr` is the sum of the base register (if `hasBase`), the scaled index register (if `hasIndex`) and the displacement, taken modulo 2^32. A term that is absent adds zero.
- R2: The scale code multiplies only the index term: 00 gives x1, 01 gives x2, 10 gives x4 and 11 gives x8.
- R3: `dispSize` selects the displacement: 00 means no displacement (zero); 01 means bits [7:0] sign-extended; 10 means bits [15:0] sign-extended; 11 means all 32 bits. Bits above the selected width are ignored.
- R4: `linAddr` equals `segBase` plus `effAddr`, modulo 2^32. `segBase` is sampled in the cycle the request is accepted.
- R5: If a request is accepted without using base and index together, `done` is high for one cycle, in the cycle right after the request. `effAddr` and `linAddr` are valid in that same cycle.
- R6: If a request uses base and index together, `busy` is high for exactly the one cycle after the request. `done` and the results follow in the next cycle.
- R7: A request strobe that arrives while `busy` is high is ignored. It changes neither the results nor the number of `done` pulses.
- R8: A request with `hasIndex`=1 and `indexSel`=4 (the stack pointer) pulses `idxFault` for one cycle, in the cycle after the request. It raises neither `done` nor `busy`. Register 4 is legal as a base, and `indexSel`=4 is legal when `hasIndex`=0.
- R9: A register write takes effect at the clock edge where it is sampled. A request sampled at that same edge still reads the old value.
- R10: After reset, `done`, `busy` and `idxFault` are low, both addresses read zero, and every register holds zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request strobe |
| hasBase | input | 1 | Base term present |
| hasIndex | input | 1 | Index term present |
| baseSel | input | 3 | Base register number |
| indexSel | input | 3 | Index register number |
| scaleCode | input | 2 | Index scale code |
| dispVal | input | 32 | Displacement value |
| dispSize | input | 2 | Displacement size tag |
| segBase | input | 32 | Segment base address |
| rfWrEn | input | 1 | Register write enable |
| rfWrAddr | input | 3 | Register write number |
| rfWrData | input | 32 | Register write data |
| effAddr | output | 32 | Effective address |
| linAddr | output | 32 | Linear address |
| done | output | 1 | Result valid pulse |
| busy | output | 1 | Two-cycle calculation in progress |
| idxFault | output | 1 | Illegal index pulse |

## Verification
The control state machine has only two states. If it sticks or goes wrong, the ports show it within two clocks. Possible symptoms are a `busy` that lasts longer than one cycle, a missing or doubled `done` after a base-plus-index request, or a `done` appearing next to `idxFault`. A wrong operand in the held register that carries the first partial sum shows only in the final sum of a two-cycle request. The benches therefore compare both addresses on every `done` against values computed from a separate model of the registers. The tests use wrapping sums and negative displacements, so that a wrong sign extension or shift amount changes the upper bits.

// File: rtl/agu_pkg.sv
package agu_pkg;
  // Strobes from control to datapath
  typedef struct packed {
    logic capPair;   // capture base+scaled index partial sum
    logic commit;    // write result registers
    logic usePair;   // final adder takes held partial operands
  } aguStrobe_t;

  typedef enum logic [1:0] {
    DISP_NONE = 2'b00,
    DISP_B8   = 2'b01,
    DISP_B16  = 2'b10,
    DISP_B32  = 2'b11
  } dispSize_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_PAIR = 1'b1
  } aguState_e;
endpackage

// File: rtl/agu_regfile.sv
module agu_regfile #(
  parameter int DATA_W = 32,
  parameter int REG_N  = 8,
  localparam int ADDR_W = $clog2(REG_N)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [ADDR_W-1:0] rdAddrA,
  input  logic [ADDR_W-1:0] rdAddrB,
  output logic [DATA_W-1:0] rdDataA,
  output logic [DATA_W-1:0] rdDataB
);
  logic [DATA_W-1:0] regQ [REG_N];

  for (genvar g = 0; g < REG_N; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (!rstN) regQ[g] <= '0;
      else if (wrEn && wrAddr == ADDR_W'(g)) regQ[g] <= wrData;
    end
  end

  assign rdDataA = regQ[rdAddrA];
  assign rdDataB = regQ[rdAddrB];
endmodule

// File: rtl/agu_ctrl.sv
module agu_ctrl
  import agu_pkg::*;
#(
  parameter int REG_N  = 8,
  parameter int SP_IDX = 4,
  localparam int ADDR_W = $clog2(REG_N)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              hasBase,
  input  logic              hasIndex,
  input  logic [ADDR_W-1:0] indexSel,
  output aguStrobe_t        stb,
  output logic              done,
  output logic              busy,
  output logic              idxFault
);
  aguState_e stateQ, stateNxt;
  logic accept, badIdx;

  assign accept = (stateQ == ST_IDLE) && reqValid;
  assign badIdx = hasIndex && (indexSel == ADDR_W'(SP_IDX));

  always_comb begin
    stb      = '0;
    stateNxt = stateQ;
    unique case (stateQ)
      ST_IDLE: begin
        if (accept && !badIdx) begin
          if (hasBase && hasIndex) begin
            stb.capPair = 1'b1;
            stateNxt    = ST_PAIR;
          end else begin
            stb.commit = 1'b1;
          end
        end
      end
      ST_PAIR: begin
        stb.commit  = 1'b1;
        stb.usePair = 1'b1;
        stateNxt    = ST_IDLE;
      end
      default: stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ   <= ST_IDLE;
      done     <= 1'b0;
      idxFault <= 1'b0;
    end else begin
      stateQ   <= stateNxt;
      done     <= stb.commit;
      idxFault <= accept && badIdx;
    end
  end

  assign busy = (stateQ == ST_PAIR);
endmodule

// File: rtl/agu_dpath.sv
module agu_dpath
  import agu_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int SCALE_W = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  aguStrobe_t         stb,
  input  logic               hasBase,
  input  logic               hasIndex,
  input  logic [DATA_W-1:0]  baseVal,
  input  logic [DATA_W-1:0]  idxVal,
  input  logic [SCALE_W-1:0] scaleCode,
  input  logic [DATA_W-1:0]  dispVal,
  input  logic [1:0]         dispSize,
  input  logic [DATA_W-1:0]  segBase,
  output logic [DATA_W-1:0]  effAddr,
  output logic [DATA_W-1:0]  linAddr
);
  logic [DATA_W-1:0] scaledIdx, dispExt, singleTerm;
  logic [DATA_W-1:0] pairSumQ, holdDispQ, holdSegQ;
  logic [DATA_W-1:0] finA, finB, finSeg, effSum, linSum;

  // index scaling: left shift by the code
  assign scaledIdx = idxVal << scaleCode;

  // displacement sign extension
  always_comb begin
    unique case (dispSize_e'(dispSize))
      DISP_NONE: dispExt = '0;
      DISP_B8:   dispExt = DATA_W'(signed'(dispVal[7:0]));
      DISP_B16:  dispExt = DATA_W'(signed'(dispVal[15:0]));
      default:   dispExt = dispVal;
    endcase
  end

  // at most one register term in single-cycle mode
  always_comb begin
    if (hasBase)       singleTerm = baseVal;
    else if (hasIndex) singleTerm = scaledIdx;
    else               singleTerm = '0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pairSumQ  <= '0;
      holdDispQ <= '0;
      holdSegQ  <= '0;
    end else if (stb.capPair) begin
      pairSumQ  <= baseVal + scaledIdx;
      holdDispQ <= dispExt;
      holdSegQ  <= segBase;
    end
  end

  // shared final adder chain
  assign finA   = stb.usePair ? pairSumQ  : singleTerm;
  assign finB   = stb.usePair ? holdDispQ : dispExt;
  assign finSeg = stb.usePair ? holdSegQ  : segBase;
  assign effSum = finA + finB;
  assign linSum = effSum + finSeg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      effAddr <= '0;
      linAddr <= '0;
    end else if (stb.commit) begin
      effAddr <= effSum;
      linAddr <= linSum;
    end
  end
endmodule

// File: rtl/addr_gen_unit.sv
module addr_gen_unit
  import agu_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int REG_N  = 8,
  parameter int SP_IDX = 4,
  localparam int ADDR_W = $clog2(REG_N)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              hasBase,
  input  logic              hasIndex,
  input  logic [ADDR_W-1:0] baseSel,
  input  logic [ADDR_W-1:0] indexSel,
  input  logic [1:0]        scaleCode,
  input  logic [DATA_W-1:0] dispVal,
  input  logic [1:0]        dispSize,
  input  logic [DATA_W-1:0] segBase,
  input  logic              rfWrEn,
  input  logic [ADDR_W-1:0] rfWrAddr,
  input  logic [DATA_W-1:0] rfWrData,
  output logic [DATA_W-1:0] effAddr,
  output logic [DATA_W-1:0] linAddr,
  output logic              done,
  output logic              busy,
  output logic              idxFault
);
  aguStrobe_t        stb;
  logic [DATA_W-1:0] baseVal, idxVal;

  agu_regfile #(.DATA_W(DATA_W), .REG_N(REG_N)) u_rf (
    .clk(clk), .rstN(rstN),
    .wrEn(rfWrEn), .wrAddr(rfWrAddr), .wrData(rfWrData),
    .rdAddrA(baseSel), .rdAddrB(indexSel),
    .rdDataA(baseVal), .rdDataB(idxVal)
  );

  agu_ctrl #(.REG_N(REG_N), .SP_IDX(SP_IDX)) u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid),
    .hasBase(hasBase), .hasIndex(hasIndex), .indexSel(indexSel),
    .stb(stb), .done(done), .busy(busy), .idxFault(idxFault)
  );

  agu_dpath #(.DATA_W(DATA_W), .SCALE_W(2)) u_dpath (
    .clk(clk), .rstN(rstN), .stb(stb),
    .hasBase(hasBase), .hasIndex(hasIndex),
    .baseVal(baseVal), .idxVal(idxVal), .scaleCode(scaleCode),
    .dispVal(dispVal), .dispSize(dispSize), .segBase(segBase),
    .effAddr(effAddr), .linAddr(linAddr)
  );
endmodule

// File: rtl/agu_chk.sv
module agu_chk #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 3,
  parameter int SP_IDX = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic              hasBase,
  input logic              hasIndex,
  input logic [ADDR_W-1:0] indexSel,
  input logic [DATA_W-1:0] segBase,
  input logic [DATA_W-1:0] effAddr,
  input logic [DATA_W-1:0] linAddr,
  input logic              done,
  input logic              busy,
  input logic              idxFault
);
  assert_pair_done_R6: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> done);
  assert_busy_once_R6: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> !busy);
  assert_busy_cause_R6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(reqValid && hasBase && hasIndex));
  assert_fault_quiet_R8: assert property (@(posedge clk) disable iff (!rstN)
    idxFault |-> (!done && !busy));
  assert_fault_cause_R8: assert property (@(posedge clk) disable iff (!rstN)
    idxFault |-> $past(reqValid && hasIndex && indexSel == ADDR_W'(SP_IDX)));
  assert_single_cause_R5: assert property (@(posedge clk) disable iff (!rstN)
    (done && !$past(busy)) |-> $past(reqValid && !(hasBase && hasIndex)));
  assert_lin_sum_R4: assert property (@(posedge clk) disable iff (!rstN)
    (done && !$past(busy)) |-> (linAddr == effAddr + $past(segBase)));
  assert_busy_ignores_R7: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> !idxFault);
endmodule

bind addr_gen_unit agu_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .SP_IDX(SP_IDX)) u_chk (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .hasBase(hasBase),
  .hasIndex(hasIndex), .indexSel(indexSel), .segBase(segBase),
  .effAddr(effAddr), .linAddr(linAddr), .done(done), .busy(busy),
  .idxFault(idxFault)
);

// File: tb/addr_gen_unit_bench.sv
`timescale 1ns/1ps
module addr_gen_unit_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0, hasBase = 1'b0, hasIndex = 1'b0;
  logic [2:0]  baseSel = '0, indexSel = '0;
  logic [1:0]  scaleCode = '0, dispSize = '0;
  logic [31:0] dispVal = '0, segBase = '0;
  logic        rfWrEn = 1'b0;
  logic [2:0]  rfWrAddr = '0;
  logic [31:0] rfWrData = '0;
  logic [31:0] effAddr, linAddr;
  logic        done, busy, idxFault;

  int total = 0;
  int bad = 0;
  logic [31:0] model [8];

  always #2.5 clk = ~clk;

  addr_gen_unit u_addr_gen_unit (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .hasBase(hasBase),
    .hasIndex(hasIndex), .baseSel(baseSel), .indexSel(indexSel),
    .scaleCode(scaleCode), .dispVal(dispVal), .dispSize(dispSize),
    .segBase(segBase), .rfWrEn(rfWrEn), .rfWrAddr(rfWrAddr),
    .rfWrData(rfWrData), .effAddr(effAddr), .linAddr(linAddr),
    .done(done), .busy(busy), .idxFault(idxFault)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] expEa(input logic hb, input logic hi,
      input logic [2:0] bs, input logic [2:0] is, input logic [1:0] sc,
      input logic [1:0] dsz, input logic [31:0] dv);
    logic [31:0] d, s;
    case (dsz)
      2'b00: d = 32'h0;
      2'b01: d = {{24{dv[7]}}, dv[7:0]};
      2'b10: d = {{16{dv[15]}}, dv[15:0]};
      default: d = dv;
    endcase
    s = model[is] * (32'd1 << sc);
    return (hb ? model[bs] : 32'h0) + (hi ? s : 32'h0) + d;
  endfunction

  task automatic writeReg(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    rfWrEn = 1'b1; rfWrAddr = a; rfWrData = d;
    @(negedge clk);
    rfWrEn = 1'b0;
    model[a] = d;
  endtask

  task automatic drive(input logic hb, input logic hi, input logic [2:0] bs,
      input logic [2:0] is, input logic [1:0] sc, input logic [1:0] dsz,
      input logic [31:0] dv, input logic [31:0] sg);
    hasBase = hb; hasIndex = hi; baseSel = bs; indexSel = is;
    scaleCode = sc; dispSize = dsz; dispVal = dv; segBase = sg;
  endtask

  // one-cycle request, checks done and both addresses
  task automatic runSingle(input string req, input logic hb, input logic hi,
      input logic [2:0] bs, input logic [2:0] is, input logic [1:0] sc,
      input logic [1:0] dsz, input logic [31:0] dv, input logic [31:0] sg);
    logic [31:0] e;
    @(negedge clk);
    e = expEa(hb, hi, bs, is, sc, dsz, dv);
    drive(hb, hi, bs, is, sc, dsz, dv, sg);
    reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    chk(req, "done", 32'(done), 32'd1);
    chk(req, "busy", 32'(busy), 32'd0);
    chk(req, "effAddr", effAddr, e);
    chk(req, "linAddr", linAddr, e + sg);
  endtask

  // base+index request, two cycles
  task automatic runPair(input string req, input logic [2:0] bs,
      input logic [2:0] is, input logic [1:0] sc, input logic [1:0] dsz,
      input logic [31:0] dv, input logic [31:0] sg);
    logic [31:0] e;
    @(negedge clk);
    e = expEa(1'b1, 1'b1, bs, is, sc, dsz, dv);
    drive(1'b1, 1'b1, bs, is, sc, dsz, dv, sg);
    reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    chk("R6", "busy first cycle", 32'(busy), 32'd1);
    chk("R6", "done first cycle", 32'(done), 32'd0);
    @(negedge clk);
    chk("R6", "done second cycle", 32'(done), 32'd1);
    chk("R6", "busy second cycle", 32'(busy), 32'd0);
    chk(req, "pair effAddr", effAddr, e);
    chk(req, "pair linAddr", linAddr, e + sg);
  endtask

  task automatic testReset();
    chk("R10", "done", 32'(done), 32'd0);
    chk("R10", "busy", 32'(busy), 32'd0);
    chk("R10", "idxFault", 32'(idxFault), 32'd0);
    chk("R10", "effAddr", effAddr, 32'd0);
    chk("R10", "linAddr", linAddr, 32'd0);
    // registers read zero
    runSingle("R10", 1'b1, 1'b0, 3'd5, 3'd0, 2'd0, 2'b00, 32'h0, 32'h0);
  endtask

  task automatic testDisp();
    runSingle("R1", 1'b0, 1'b0, 3'd0, 3'd0, 2'd0, 2'b11, 32'h500, 32'h10000);
    runSingle("R3", 1'b0, 1'b0, 3'd0, 3'd0, 2'd0, 2'b01, 32'h80, 32'h0);
    runSingle("R3", 1'b0, 1'b0, 3'd0, 3'd0, 2'd0, 2'b10, 32'h8001, 32'h0);
    runSingle("R3", 1'b0, 1'b0, 3'd0, 3'd0, 2'd0, 2'b01, 32'hABCD007F, 32'h0);
    runSingle("R3", 1'b1, 1'b0, 3'd0, 3'd0, 2'd0, 2'b00, 32'hFFFF_FFFF, 32'h0);
  endtask

  task automatic testSingleModes();
    runSingle("R5", 1'b1, 1'b0, 3'd0, 3'd0, 2'd0, 2'b01, 32'h24, 32'h300);
    runSingle("R8", 1'b1, 1'b0, 3'd4, 3'd0, 2'd0, 2'b00, 32'h0, 32'h0);
    runSingle("R2", 1'b0, 1'b1, 3'd0, 3'd6, 2'd3, 2'b01, 32'h10, 32'h0);
    for (int s = 0; s < 4; s++)
      runSingle("R2", 1'b0, 1'b1, 3'd0, 3'd2, 2'(s), 2'b00, 32'h0, 32'h0);
    runSingle("R4", 1'b0, 1'b1, 3'd0, 3'd7, 2'd1, 2'b11, 32'h4, 32'hFFFF_0000);
  endtask

  task automatic testPair();
    runPair("R1", 3'd0, 3'd2, 2'd2, 2'b01, 32'h24, 32'h5000);
    runPair("R1", 3'd1, 3'd7, 2'd0, 2'b01, 32'h20, 32'h0);
    runPair("R4", 3'd3, 3'd5, 2'd0, 2'b10, 32'hFFF0, 32'h8000_0000);
    runPair("R2", 3'd4, 3'd6, 2'd3, 2'b00, 32'h0, 32'h1);
  endtask

  task automatic testIgnoreBusy();
    logic [31:0] e;
    @(negedge clk);
    e = expEa(1'b1, 1'b1, 3'd0, 3'd2, 2'd1, 2'b11, 32'h7);
    drive(1'b1, 1'b1, 3'd0, 3'd2, 2'd1, 2'b11, 32'h7, 32'h40);
    reqValid = 1'b1;
    @(negedge clk);
    // strobe held during busy with other fields
    drive(1'b1, 1'b0, 3'd5, 3'd4, 2'd0, 2'b11, 32'h1234, 32'h0);
    chk("R7", "busy", 32'(busy), 32'd1);
    @(negedge clk);
    reqValid = 1'b0;
    chk("R7", "done", 32'(done), 32'd1);
    chk("R7", "effAddr first request", effAddr, e);
    chk("R7", "linAddr first request", linAddr, e + 32'h40);
    @(negedge clk);
    chk("R7", "no extra done", 32'(done), 32'd0);
    chk("R7", "effAddr held", effAddr, e);
    // a fault-shaped strobe during busy is ignored too
    @(negedge clk);
    drive(1'b1, 1'b1, 3'd0, 3'd2, 2'd0, 2'b00, 32'h0, 32'h0);
    reqValid = 1'b1;
    @(negedge clk);
    drive(1'b0, 1'b1, 3'd0, 3'd4, 2'd0, 2'b00, 32'h0, 32'h0);
    @(negedge clk);
    reqValid = 1'b0;
    chk("R7", "no fault during busy", 32'(idxFault), 32'd0);
    chk("R7", "done after busy", 32'(done), 32'd1);
    @(negedge clk);
    chk("R7", "no fault afterwards", 32'(idxFault), 32'd0);
  endtask

  task automatic testFault();
    logic [31:0] eBefore;
    eBefore = effAddr;
    @(negedge clk);
    drive(1'b1, 1'b1, 3'd0, 3'd4, 2'd0, 2'b01, 32'h5, 32'h0);
    reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    chk("R8", "idxFault", 32'(idxFault), 32'd1);
    chk("R8", "done on fault", 32'(done), 32'd0);
    chk("R8", "busy on fault", 32'(busy), 32'd0);
    chk("R8", "effAddr unchanged", effAddr, eBefore);
    @(negedge clk);
    chk("R8", "fault one cycle", 32'(idxFault), 32'd0);
    chk("R8", "no late done", 32'(done), 32'd0);
    runSingle("R8", 1'b1, 1'b0, 3'd0, 3'd4, 2'd3, 2'b00, 32'h0, 32'h0);
  endtask

  task automatic testWriteOrder();
    logic [31:0] oldV;
    oldV = model[7];
    @(negedge clk);
    drive(1'b1, 1'b0, 3'd7, 3'd0, 2'd0, 2'b00, 32'h0, 32'h0);
    reqValid = 1'b1;
    rfWrEn = 1'b1; rfWrAddr = 3'd7; rfWrData = 32'h999;
    @(negedge clk);
    reqValid = 1'b0; rfWrEn = 1'b0;
    model[7] = 32'h999;
    chk("R9", "same-edge reads old", effAddr, oldV);
    runSingle("R9", 1'b1, 1'b0, 3'd7, 3'd0, 2'd0, 2'b00, 32'h0, 32'h0);
  endtask

  initial begin
    #1_000_000;
    total++; bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 8; i++) model[i] = 32'h0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    writeReg(3'd0, 32'h0000_1000);
    writeReg(3'd1, 32'hFFFF_FFF0);
    writeReg(3'd2, 32'h0000_0010);
    writeReg(3'd3, 32'h8000_0000);
    writeReg(3'd4, 32'h0000_7000);
    writeReg(3'd5, 32'h2000_0000);
    writeReg(3'd6, 32'h0000_0003);
    writeReg(3'd7, 32'h0000_0100);
    testDisp();
    testSingleModes();
    testPair();
    testIgnoreBusy();
    testFault();
    testWriteOrder();
    repeat (2) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule